// File: doc/BRIEF.md
# Bit-Test Conditional Subroutine Call Unit

This unit is the program-flow slice of a processor sequencer that runs a "call subroutine when a chosen bit is zero" operation. Each operation presents a 32-bit operand, a 5-bit index that picks one of its bits, a signed 32-bit displacement, the program counter and the status word. The program counter input already points at the instruction that follows the call. When the chosen bit is zero the unit pushes the return address and the status word onto its own hardware stack. It then redirects the program counter to the input PC plus the displacement. When the chosen bit is one, the program counter continues in sequence.

The unit owns a 15-level stack. Each level holds a high word, which is the return address, and a low word, which is the status word. A 4-bit pointer addresses the stack, and a value of 0 means empty. The operand may be taken from the top high word instead of the operand input. That read pops the stack, so a taken call writes its return frame back onto the level it just vacated. Both overflow and underflow of the pointer wrap it and set sticky flags.

A request to update the addressing register is raised for every operation, whatever the outcome of the bit test. Each operation is applied on a single clock edge while `op_valid` is high. The new PC, the stack write and the pointer change all appear together after that edge.

Top module: `bsub_branch_unit`

## Requirements
- R1: The tested bit is bit `bit_idx` (0 to 31) of the operand; a zero there makes `taken` 1 after the edge, a one makes it 0.
- R2: On a taken operation, `next_pc` becomes `pc_in + disp` modulo 2^32. The pointer rises by one, and the new top level holds `pc_in` in its high word and `sr_in`, unaltered, in its low word.
- R3: On a not-taken operation, `next_pc` becomes `pc_in`, and nothing is pushed.
- R4: `ea_update` is 1 in the cycle after every valid operation, taken or not, and 0 after a cycle without one.
- R5: With `src_is_top` = 1, the operand is the top high word and the pointer is decremented. A taken call then leaves the pointer unchanged and overwrites that level with the new frame. A not-taken one leaves it one lower.
- R6: With the pointer at 0, `top_hi` and `top_lo` read as zero. A top-word operand read then yields operand 0, sets the sticky `underflow` flag and wraps the pointer to 15 before any push.
- R7: A push with the pointer at 15 sets the sticky `overflow` flag and wraps the pointer to 0.
- R8: Once set, `overflow` and `underflow` stay set until reset.
- R9: A cycle with `op_valid` = 0 changes no state: `next_pc`, `taken`, the pointer, the flags and the stack top all hold.
- R10: After reset, `next_pc`, `taken`, `ea_update`, `sp`, `overflow` and `underflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Apply one operation on this edge |
| src_is_top | input | 1 | Take the operand from the top high word (pops) |
| src_operand | input | 32 | Operand when not taken from the stack |
| bit_idx | input | 5 | Index of the tested bit |
| disp | input | 32 | Two's complement displacement |
| pc_in | input | 32 | Address of the following instruction |
| sr_in | input | 32 | Status word to save |
| next_pc | output | 32 | Registered next program counter |
| taken | output | 1 | Registered outcome of the last operation |
| ea_update | output | 1 | Address-register update request |
| sp | output | 4 | Stack pointer, 0 = empty |
| top_hi | output | 32 | High word at the pointer |
| top_lo | output | 32 | Low word at the pointer |
| overflow | output | 1 | Sticky push-on-full flag |
| underflow | output | 1 | Sticky pop-on-empty flag |

## Verification
The hardest cases to reach are the pointer corners of the top-word operand. Here a pop and a push fall on one edge, and on an empty stack that pair produces an underflow, a wrap to 15, an overflow and a wrap back to 0. The stimulus first fills every level with taken calls so that each level holds a known frame. One more call then forces the overflow. After that a top-word operation on the empty stack exercises the double wrap. Finally, a few pushes followed by top-word reads whose stored return addresses have chosen bit patterns cover both the overwrite of the same level and the net pop.

// File: rtl/bsub_pkg.sv
package bsub_pkg;
  localparam int WORD_W      = 32;
  localparam int STACK_DEPTH = 15;
  localparam int IDX_W       = $clog2(WORD_W);
endpackage

// File: rtl/bsub_bit_test.sv
module bsub_bit_test #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  operand,
  input  logic [IW-1:0] idx,
  output logic          bit_clear
);
  logic [W-1:0] sel_mask;

  // one-hot select of the tested position
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_sel
      assign sel_mask[g] = (idx == IW'(g)) & operand[g];
    end
  endgenerate

  assign bit_clear = ~(|sel_mask);

  always_comb begin
    assert (bit_clear == ~operand[idx]) else $error("p_bit_select_r1");
  end
endmodule

// File: rtl/bsub_target.sv
module bsub_target #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  output logic [W-1:0] target
);
  // modulo 2^W sum, no carry out
  assign target = base + offset;
endmodule

// File: rtl/bsub_stack.sv
module bsub_stack #(
  parameter int W     = 32,
  parameter int DEPTH = 15,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int SLOTS = 1 << SP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pop_req,
  input  logic            push_req,
  input  logic [W-1:0]    push_hi,
  input  logic [W-1:0]    push_lo,
  output logic [W-1:0]    top_hi,
  output logic [W-1:0]    top_lo,
  output logic [SP_W-1:0] sp,
  output logic            overflow,
  output logic            underflow
);
  logic [2*W-1:0]  mem [0:SLOTS-1];
  logic [SP_W-1:0] sp_q, sp_mid, sp_new;
  logic            ovf_q, unf_q;
  logic [2*W-1:0]  rd_word;

  // pop happens before push within one operation
  always_comb begin
    sp_mid = pop_req  ? sp_q - 1'b1   : sp_q;
    sp_new = push_req ? sp_mid + 1'b1 : sp_mid;
  end

  // storage: one write port, no reset, RAM-inferable
  always_ff @(posedge clk) begin
    if (push_req) mem[sp_new] <= {push_hi, push_lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      sp_q <= sp_new;
      if (pop_req && sp_q == '0) unf_q <= 1'b1;
      if (push_req && sp_mid == SP_W'(DEPTH)) ovf_q <= 1'b1;
    end
  end

  assign rd_word   = mem[sp_q];
  assign top_hi    = (sp_q == '0) ? '0 : rd_word[2*W-1:W];
  assign top_lo    = (sp_q == '0) ? '0 : rd_word[W-1:0];
  assign sp        = sp_q;
  assign overflow  = ovf_q;
  assign underflow = unf_q;

  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req) |=> sp_q == SP_W'($past(sp_q) + 1'b1));

  p_same_level_r5: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req) |=> $stable(sp_q));

  p_underflow_set_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_req && sp_q == '0) |=> unf_q);

  p_overflow_set_r7: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && sp_q == SP_W'(DEPTH)) |=> (ovf_q && sp_q == '0));

  p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);

  p_no_underflow_clear_r8: assert property (@(posedge clk) disable iff (rst)
    unf_q |=> unf_q);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!push_req && !pop_req) |=> $stable(sp_q));
endmodule

// File: rtl/bsub_branch_unit.sv
module bsub_branch_unit
  import bsub_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int DEPTH = STACK_DEPTH,
  localparam int IW   = $clog2(W),
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic            src_is_top,
  input  logic [W-1:0]    src_operand,
  input  logic [IW-1:0]   bit_idx,
  input  logic [W-1:0]    disp,
  input  logic [W-1:0]    pc_in,
  input  logic [W-1:0]    sr_in,
  output logic [W-1:0]    next_pc,
  output logic            taken,
  output logic            ea_update,
  output logic [SP_W-1:0] sp,
  output logic [W-1:0]    top_hi,
  output logic [W-1:0]    top_lo,
  output logic            overflow,
  output logic            underflow
);
  logic [W-1:0] operand_c, target_c;
  logic         bit_clear_c, do_pop, do_push;
  logic [W-1:0] next_pc_q;
  logic         taken_q, ea_q;

  // top_hi already reads zero on an empty stack
  assign operand_c = src_is_top ? top_hi : src_operand;
  assign do_pop    = op_valid & src_is_top;
  assign do_push   = op_valid & bit_clear_c;

  bsub_bit_test #(.W(W)) u_test (
    .operand   (operand_c),
    .idx       (bit_idx),
    .bit_clear (bit_clear_c)
  );

  bsub_target #(.W(W)) u_target (
    .base   (pc_in),
    .offset (disp),
    .target (target_c)
  );

  bsub_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .pop_req   (do_pop),
    .push_req  (do_push),
    .push_hi   (pc_in),
    .push_lo   (sr_in),
    .top_hi    (top_hi),
    .top_lo    (top_lo),
    .sp        (sp),
    .overflow  (overflow),
    .underflow (underflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_q <= '0;
      taken_q   <= 1'b0;
      ea_q      <= 1'b0;
    end else begin
      ea_q <= op_valid;
      if (op_valid) begin
        taken_q   <= bit_clear_c;
        next_pc_q <= bit_clear_c ? target_c : pc_in;
      end
    end
  end

  assign next_pc   = next_pc_q;
  assign taken     = taken_q;
  assign ea_update = ea_q;

  p_taken_target_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && bit_clear_c) |=> (taken && next_pc == $past(pc_in + disp)));

  p_frame_saved_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && bit_clear_c) |=> (top_lo == $past(sr_in) || sp == '0));

  p_sequential_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !bit_clear_c) |=> (!taken && next_pc == $past(pc_in)));

  p_ea_always_r4: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> ea_update);

  p_empty_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (sp == '0) |-> (top_hi == '0 && top_lo == '0));

  p_idle_pc_r9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(next_pc) && $stable(taken) && !ea_update));
endmodule

// File: tb/bsub_branch_unit_bench.sv
`timescale 1ns/1ps
module bsub_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, src_is_top;
  logic [31:0] src_operand, disp, pc_in, sr_in;
  logic [4:0]  bit_idx;
  logic [31:0] next_pc, top_hi, top_lo;
  logic        taken, ea_update, overflow, underflow;
  logic [3:0]  sp;

  int nchk = 0;
  int nerr = 0;

  // behavioural reference state
  logic [31:0] m_hi [16];
  logic [31:0] m_lo [16];
  int          m_sp;
  bit          m_ovf, m_unf, m_taken, m_ea;
  logic [31:0] m_pc;

  always #2.5 clk = ~clk;

  bsub_branch_unit u_bsub_branch_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .src_is_top(src_is_top),
    .src_operand(src_operand), .bit_idx(bit_idx), .disp(disp),
    .pc_in(pc_in), .sr_in(sr_in), .next_pc(next_pc), .taken(taken),
    .ea_update(ea_update), .sp(sp), .top_hi(top_hi), .top_lo(top_lo),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "next_pc", next_pc, m_pc);
    chk(tag, "taken", {31'b0, taken}, {31'b0, m_taken});
    chk("R4", "ea_update", {31'b0, ea_update}, {31'b0, m_ea});
    chk(tag, "sp", {28'b0, sp}, 32'(m_sp));
    chk(tag, "overflow", {31'b0, overflow}, {31'b0, m_ovf});
    chk(tag, "underflow", {31'b0, underflow}, {31'b0, m_unf});
    chk(tag, "top_hi", top_hi, (m_sp == 0) ? 32'h0 : m_hi[m_sp]);
    chk(tag, "top_lo", top_lo, (m_sp == 0) ? 32'h0 : m_lo[m_sp]);
  endtask

  task automatic step(input bit v, input bit top, input logic [31:0] src,
                      input logic [4:0] idx, input logic [31:0] d,
                      input logic [31:0] pc, input logic [31:0] sr,
                      input string tag);
    logic [31:0] opnd;
    bit tk;
    @(negedge clk);
    op_valid = v; src_is_top = top; src_operand = src;
    bit_idx = idx; disp = d; pc_in = pc; sr_in = sr;
    m_ea = v;
    if (v) begin
      opnd = src;
      if (top) begin
        opnd = (m_sp == 0) ? 32'h0 : m_hi[m_sp];
        if (m_sp == 0) m_unf = 1;
        m_sp = (m_sp + 15) % 16;
      end
      tk = (opnd[idx] == 1'b0);
      m_taken = tk;
      if (tk) begin
        if (m_sp == 15) m_ovf = 1;
        m_sp = (m_sp + 1) % 16;
        m_hi[m_sp] = pc;
        m_lo[m_sp] = sr;
        m_pc = pc + d;
      end else begin
        m_pc = pc;
      end
    end
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 0; src_is_top = 0; src_operand = 0;
    bit_idx = 0; disp = 0; pc_in = 0; sr_in = 0;
    m_sp = 0; m_ovf = 0; m_unf = 0; m_taken = 0; m_ea = 0; m_pc = 0;
    for (int i = 0; i < 16; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    compare_all("R10");
    @(negedge clk);
    rst = 1'b0;

    // idle cycle
    step(0, 0, 32'hFFFF_FFFF, 5'd3, 32'h10, 32'h100, 32'h5, "R9");
    // bit set: sequential, nothing pushed
    step(1, 0, 32'h0000_0008, 5'd3, 32'h40, 32'h200, 32'h7, "R3");
    step(1, 0, 32'h8000_0000, 5'd31, 32'h40, 32'h204, 32'h7, "R3");
    // bit clear at various positions fills all 15 levels
    for (int i = 0; i < 15; i++) begin
      step(1, 0, ~(32'h1 << i), 5'(i), (i % 2) ? 32'hFFFF_FFF0 : 32'h0000_0020,
           32'h1000 + 32'(i) * 32'h11, 32'hA500_0000 | 32'(i), "R1");
    end
    // target wrap modulo 2^32 with a push onto the full stack
    step(1, 0, 32'h0, 5'd0, 32'h0000_0030, 32'hFFFF_FFE0, 32'h1234_5678, "R7");
    step(0, 0, 32'h0, 5'd0, 32'h0, 32'h0, 32'h0, "R8");
    // top-word read on the empty stack
    step(1, 1, 32'hFFFF_FFFF, 5'd9, 32'h100, 32'h3000, 32'h33, "R6");
    step(0, 0, 32'h0, 5'd0, 32'h0, 32'h0, 32'h0, "R8");
    // build frames with chosen bit patterns, then read them back
    step(1, 0, 32'h0, 5'd2, 32'h8, 32'h0000_0004, 32'h44, "R2");
    step(1, 0, 32'h0, 5'd2, 32'h8, 32'h0000_0003, 32'h45, "R2");
    step(1, 1, 32'h0, 5'd2, 32'h80, 32'h0000_0F00, 32'h46, "R5");
    step(1, 1, 32'h0, 5'd8, 32'h80, 32'h0000_0F04, 32'h47, "R5");
    step(1, 1, 32'h0, 5'd2, 32'h80, 32'h0000_0F08, 32'h48, "R5");
    step(1, 0, 32'hFFFF_FFFF, 5'd17, 32'h1, 32'h0000_0777, 32'h49, "R3");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, ($urandom % 3) == 0, $urandom, 5'($urandom),
           $urandom, $urandom, $urandom, "R2");
    end

    // reset returns everything to zero
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    m_sp = 0; m_ovf = 0; m_unf = 0; m_taken = 0; m_ea = 0; m_pc = 0;
    compare_all("R10");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule